// File: doc/BRIEF.md
# Console Keyboard and Display Register Block

This block is a slave on a processor load/store bus. It presents a keyboard receiver and a display transmitter as four word registers placed at the top of the address space. Bytes from an external keyboard arrive on a byte-valid input. The block latches each byte and raises a receive-ready flag. The transmitter takes a byte from a store to its data register and emits it on a one-cycle byte-out strobe. Its ready flag stays low while the byte is in flight.

The transmitter is complete when the terminal pulses a done input or when an internal delay of `TX_DELAY` cycles runs out, whichever comes first. Each direction has its own interrupt enable. The two enables combine into one level-sensitive interrupt request, so software can either poll the ready bits or service the console from an interrupt handler.

Bus reads return data combinationally in the same cycle. Writes, and the clearing effect of a read, take hold at the next rising clock edge.

Top module: `console_regs`

## Requirements
- R1: With `BASE` = 0xFFFF0000, the registers decode at word offsets 0x0 (receiver control), 0x4 (receiver data), 0x8 (transmitter control) and 0xC (transmitter data). Any other address reads as zero, and a write to it changes no register.
- R2: A cycle with `kbd_valid` high latches `kbd_byte` and sets receiver ready, which is bit 0 of receiver control. The receiver data register returns the held byte in bits 7..0.
- R3: A read of receiver data clears receiver ready at the following edge. A byte arriving while ready is set replaces the held byte. A byte arriving in the same cycle as a data read wins: ready stays 1, the new byte is held, and the read returns the old byte.
- R4: Bit 1 of receiver control is a writable interrupt enable. Bit 0 ignores writes.
- R5: Bit 1 of transmitter control is a writable interrupt enable. Bit 0, transmitter ready, ignores writes.
- R6: A write to transmitter data while transmitter ready is 1 clears ready at the next edge. In the cycle after that write, `tx_strobe` is high for exactly one cycle, with the written bits 7..0 on `tx_byte`.
- R7: Transmitter ready returns to 1 at the edge that samples `tx_done` high while the transmitter is busy. Otherwise it returns `TX_DELAY` edges after the accepting edge.
- R8: A write to transmitter data while transmitter ready is 0 is ignored: there is no strobe, `tx_byte` is unchanged, and the byte read back is unchanged.
- R9: `irq` is high exactly while (receiver ready AND receiver enable) OR (transmitter ready AND transmitter enable).
- R10: Control registers read zero in bits 31..2. Data registers read zero in bits 31..8. Transmitter data reads back the last accepted byte.
- R11: After reset, receiver ready is 0, transmitter ready is 1, both enables are 0, and `irq` is 0.
- R12: A write to receiver data changes neither the held byte nor receiver ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the same cycle |
| kbd_valid | input | 1 | Keyboard byte present this cycle |
| kbd_byte | input | 8 | Keyboard byte |
| tx_done | input | 1 | Terminal finished the current byte |
| tx_strobe | output | 1 | One-cycle pulse: a byte is sent |
| tx_byte | output | 8 | Byte being sent |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest cases to reach from the ports are collisions in a single cycle: a keyboard byte arriving in the same cycle that the receive data register is read, and a second transmit store landing while the first byte is still in flight. Directed steps line these events up on exact negative-edge slots. They also time the transmitter completion to the edge, against both the done pulse and the internal delay. Random mixes of pushes, reads and control writes then compare every read value and the interrupt line against a bench model.

// File: rtl/console_pkg.sv
package console_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 32;

    // word index within the register window (address bits 3..2)
    typedef enum logic [1:0] {
        SEL_RX_CTRL = 2'd0,
        SEL_RX_DATA = 2'd1,
        SEL_TX_CTRL = 2'd2,
        SEL_TX_DATA = 2'd3
    } reg_sel_e;

    localparam int unsigned READY_BIT = 0;
    localparam int unsigned IE_BIT    = 1;

    typedef struct packed {
        logic              ready;
        logic              ie;
        logic [BYTE_W-1:0] data;
    } rx_state_t;
endpackage

// File: rtl/console_rx.sv
module console_rx
    import console_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              ie_wr,
    input  logic              ie_val,
    input  logic              data_rd,
    output logic              ready,
    output logic              ie,
    output logic [BYTE_W-1:0] data
);
    rx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ie_wr)   s_d.ie    = ie_val;
        if (data_rd) s_d.ready = 1'b0;
        // an arriving byte takes priority over the clearing read
        if (in_valid) begin
            s_d.ready = 1'b1;
            s_d.data  = in_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready = s_q.ready;
    assign ie    = s_q.ie;
    assign data  = s_q.data;
endmodule

// File: rtl/console_tx.sv
module console_tx
    import console_pkg::*;
#(
    parameter int unsigned TX_DELAY = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ie_wr,
    input  logic              ie_val,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              done,
    output logic              ready,
    output logic              ie,
    output logic              strobe,
    output logic [BYTE_W-1:0] data
);
    localparam int unsigned CW = $clog2(TX_DELAY + 2);
    localparam logic [CW-1:0] CNT_LOAD = CW'(TX_DELAY);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    typedef struct packed {
        logic              ready;
        logic              ie;
        logic              strobe;
        logic [BYTE_W-1:0] data;
        logic [CW-1:0]     cnt;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic      timer_end;

    generate
        if (TX_DELAY > 0) begin : g_timer
            assign timer_end = (s_q.cnt == CNT_LAST);
        end else begin : g_no_timer
            assign timer_end = 1'b0;
        end
    endgenerate

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (ie_wr) s_d.ie = ie_val;
        if (!s_q.ready) begin
            if (done || timer_end) s_d.ready = 1'b1;
            if (s_q.cnt != '0)     s_d.cnt   = s_q.cnt - CNT_LAST;
        end
        if (data_wr && s_q.ready) begin
            s_d.ready  = 1'b0;
            s_d.strobe = 1'b1;
            s_d.data   = wdata;
            s_d.cnt    = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ready <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready  = s_q.ready;
    assign ie     = s_q.ie;
    assign strobe = s_q.strobe;
    assign data   = s_q.data;
endmodule

// File: rtl/console_regs.sv
module console_regs
    import console_pkg::*;
#(
    parameter logic [31:0] BASE     = 32'hFFFF_0000,
    parameter int unsigned TX_DELAY = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        kbd_valid,
    input  logic [7:0]  kbd_byte,
    input  logic        tx_done,
    output logic        tx_strobe,
    output logic [7:0]  tx_byte,
    output logic        irq
);
    localparam int unsigned PAD_B = WORD_W - BYTE_W;

    logic       hit;
    reg_sel_e   sel_idx;
    logic       wr_rx_ctrl, wr_tx_ctrl, tx_wr_req, rd_rx_data;
    logic       rx_ready, rx_ie, tx_ready, tx_ie;
    logic [7:0] rx_byte;

    assign hit     = bus_sel && (bus_addr[31:4] == BASE[31:4]) && (bus_addr[1:0] == 2'b00);
    assign sel_idx = reg_sel_e'(bus_addr[3:2]);

    assign wr_rx_ctrl = hit && bus_we  && (sel_idx == SEL_RX_CTRL);
    assign wr_tx_ctrl = hit && bus_we  && (sel_idx == SEL_TX_CTRL);
    assign tx_wr_req  = hit && bus_we  && (sel_idx == SEL_TX_DATA);
    assign rd_rx_data = hit && !bus_we && (sel_idx == SEL_RX_DATA);

    console_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(kbd_valid),
        .in_byte (kbd_byte),
        .ie_wr   (wr_rx_ctrl),
        .ie_val  (bus_wdata[IE_BIT]),
        .data_rd (rd_rx_data),
        .ready   (rx_ready),
        .ie      (rx_ie),
        .data    (rx_byte)
    );

    console_tx #(.TX_DELAY(TX_DELAY)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .ie_wr  (wr_tx_ctrl),
        .ie_val (bus_wdata[IE_BIT]),
        .data_wr(tx_wr_req),
        .wdata  (bus_wdata[BYTE_W-1:0]),
        .done   (tx_done),
        .ready  (tx_ready),
        .ie     (tx_ie),
        .strobe (tx_strobe),
        .data   (tx_byte)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit && !bus_we) begin
            unique case (sel_idx)
                SEL_RX_CTRL: begin
                    bus_rdata[READY_BIT] = rx_ready;
                    bus_rdata[IE_BIT]    = rx_ie;
                end
                SEL_RX_DATA: bus_rdata = {{PAD_B{1'b0}}, rx_byte};
                SEL_TX_CTRL: begin
                    bus_rdata[READY_BIT] = tx_ready;
                    bus_rdata[IE_BIT]    = tx_ie;
                end
                SEL_TX_DATA: bus_rdata = {{PAD_B{1'b0}}, tx_byte};
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irq = (rx_ready && rx_ie) || (tx_ready && tx_ie);
endmodule

// File: rtl/console_regs_chk.sv
module console_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [31:0] bus_rdata,
    input logic        kbd_valid,
    input logic        tx_wr_req,
    input logic        rx_ready,
    input logic        rx_ie,
    input logic        tx_ready,
    input logic        tx_ie,
    input logic        tx_strobe,
    input logic [7:0]  tx_byte,
    input logic        irq
);
    assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_valid |=> rx_ready);

    assert_tx_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_req && tx_ready) |=> (!tx_ready && tx_strobe));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);

    assert_tx_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_req && !tx_ready) |=> (!tx_strobe && $stable(tx_byte)));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq);

    assert_irq_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rx_ie) |-> irq);

    assert_rdata_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |-> (bus_rdata[31:8] == 24'h0));
endmodule

bind console_regs console_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid),
    .tx_wr_req(tx_wr_req),
    .rx_ready (rx_ready),
    .rx_ie    (rx_ie),
    .tx_ready (tx_ready),
    .tx_ie    (tx_ie),
    .tx_strobe(tx_strobe),
    .tx_byte  (tx_byte),
    .irq      (irq)
);

// File: tb/console_regs_test.sv
module console_regs_test;
    localparam int PERIOD = 10;
    localparam int DLY    = 6;
    localparam logic [31:0] A_RXC = 32'hFFFF_0000;
    localparam logic [31:0] A_RXD = 32'hFFFF_0004;
    localparam logic [31:0] A_TXC = 32'hFFFF_0008;
    localparam logic [31:0] A_TXD = 32'hFFFF_000C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kbd_valid = 1'b0;
    logic [7:0]  kbd_byte = '0;
    logic        tx_done = 1'b0;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        irq;

    int total = 0, bad = 0;
    logic       m_rxr = 0, m_rxie = 0, m_txr = 1, m_txie = 0;
    logic [7:0] m_rxb = 0, m_txb = 0;
    logic [31:0] rd_val;

    always #(PERIOD/2) clk = ~clk;

    console_regs #(.TX_DELAY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_valid(kbd_valid), .kbd_byte(kbd_byte), .tx_done(tx_done),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
    );

    function automatic logic [31:0] ctrl_word(logic r, logic e);
        return {30'h0, e, r};
    endfunction

    function automatic logic exp_irq();
        return (m_rxr && m_rxie) || (m_txr && m_txie);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // every bus task starts just after a falling edge and ends at the next one
    task automatic bus_rd(input logic [31:0] a);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 rd_val = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic push(input logic [7:0] b);
        kbd_valid = 1; kbd_byte = b;
        @(negedge clk);
        kbd_valid = 0;
        m_rxr = 1; m_rxb = b;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input string tag);
        #1 check(irq == exp_irq(), tag, {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle(2);
        rst_n = 1;
        idle(1);

        // R11 reset state
        bus_rd(A_RXC); check(rd_val == 32'h0, "R11 rx ctrl", rd_val, 32'h0);
        bus_rd(A_TXC); check(rd_val == 32'h1, "R11 tx ctrl", rd_val, 32'h1);
        chk_irq("R11 irq");

        // R2 receive
        push(8'h41);
        bus_rd(A_RXC); check(rd_val == 32'h1, "R2 ready", rd_val, 32'h1);
        bus_rd(A_RXD); check(rd_val == 32'h41, "R2 data", rd_val, 32'h41);
        m_rxr = 0;
        bus_rd(A_RXC); check(rd_val == 32'h0, "R3 clear on read", rd_val, 32'h0);

        // R3 overwrite
        push(8'h11); push(8'h22);
        bus_rd(A_RXD); check(rd_val == 32'h22, "R3 overwrite", rd_val, 32'h22);
        m_rxr = 0;

        // R3 collision: arrival and data read in one cycle
        push(8'h33);
        kbd_valid = 1; kbd_byte = 8'h44;
        bus_rd(A_RXD);
        kbd_valid = 0; m_rxr = 1; m_rxb = 8'h44;
        check(rd_val == 32'h33, "R3 collide old byte", rd_val, 32'h33);
        bus_rd(A_RXC); check(rd_val == 32'h1, "R3 collide ready kept", rd_val, 32'h1);
        bus_rd(A_RXD); check(rd_val == 32'h44, "R3 collide new byte", rd_val, 32'h44);
        m_rxr = 0;

        // R12 receiver data is read-only
        push(8'h5A);
        bus_wr(A_RXD, 32'h0000_00FF);
        bus_rd(A_RXC); check(rd_val == 32'h1, "R12 ready kept", rd_val, 32'h1);

        // R4 enable writable, ready read-only; R9 irq from receiver
        bus_wr(A_RXC, 32'hFFFF_FFFE); m_rxie = 1;
        bus_rd(A_RXC); check(rd_val == 32'h3, "R4 ie set ready kept", rd_val, 32'h3);
        chk_irq("R9 rx irq");
        bus_rd(A_RXD); check(rd_val == 32'h5A, "R12 byte kept", rd_val, 32'h5A);
        m_rxr = 0;
        chk_irq("R9 rx irq drop");

        // R1 unmapped window and misaligned address
        bus_rd(32'hFFFF_0010); check(rd_val == 32'h0, "R1 unmapped read", rd_val, 32'h0);
        bus_rd(32'hFFFE_0000); check(rd_val == 32'h0, "R1 other base", rd_val, 32'h0);
        bus_wr(32'hFFFF_0018, 32'h2);
        bus_wr(32'hFFFF_000A, 32'h2);
        bus_rd(A_TXC); check(rd_val == 32'h1, "R1 stray write no effect", rd_val, 32'h1);

        // R6 accept, R8 ignore while busy, R7 delay completion
        bus_wr(A_TXD, 32'h0000_01A5);
        check(tx_strobe === 1'b1 && tx_byte == 8'hA5, "R6 strobe", {23'h0, tx_strobe, tx_byte}, 32'h1A5);
        bus_wr(A_TXD, 32'h0000_0077);
        check(tx_strobe === 1'b0 && tx_byte == 8'hA5, "R8 busy write", {23'h0, tx_strobe, tx_byte}, 32'h0A5);
        bus_rd(A_TXC); check(rd_val == 32'h0, "R6 ready low", rd_val, 32'h0);
        bus_wr(A_TXC, 32'h1); // R5: bit0 write ignored, ie stays 0
        idle(DLY - 4);
        bus_rd(A_TXC); check(rd_val == 32'h0, "R7 still busy", rd_val, 32'h0);
        bus_rd(A_TXC); check(rd_val == 32'h1, "R7 delay end", rd_val, 32'h1);
        bus_rd(A_TXD); check(rd_val == 32'hA5, "R8/R10 readback", rd_val, 32'hA5);
        m_txb = 8'hA5;
        bus_wr(A_TXC, 32'h2); m_txie = 1;
        bus_rd(A_TXC); check(rd_val == 32'h3, "R5 ie set", rd_val, 32'h3);
        chk_irq("R9 tx irq");

        // R7 early done pulse
        bus_wr(A_TXD, 32'h5C); m_txr = 0;
        chk_irq("R9 tx irq busy");
        tx_done = 1; idle(1); tx_done = 0; m_txr = 1; m_txb = 8'h5C;
        bus_rd(A_TXC); check(rd_val == 32'h3, "R7 done pulse", rd_val, 32'h3);

        // random mix against the model
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [31:0] w;
            op = $urandom_range(0, 5);
            w = $urandom;
            case (op)
                0: push(w[7:0]);
                1: begin
                    bus_rd(A_RXD);
                    check(rd_val == {24'h0, m_rxb}, "R3 rand data", rd_val, {24'h0, m_rxb});
                    m_rxr = 0;
                end
                2: begin
                    bus_rd(A_RXC);
                    check(rd_val == ctrl_word(m_rxr, m_rxie), "R2 rand rx ctrl", rd_val, ctrl_word(m_rxr, m_rxie));
                end
                3: begin bus_wr(A_RXC, w); m_rxie = w[1]; end
                4: begin bus_wr(A_TXC, w); m_txie = w[1]; end
                default: begin
                    bus_wr(A_TXD, w); m_txr = 0; m_txb = w[7:0];
                    check(tx_strobe === 1'b1 && tx_byte == w[7:0], "R6 rand strobe",
                          {23'h0, tx_strobe, tx_byte}, {23'h1, w[7:0]});
                    chk_irq("R9 rand busy");
                    if (w[8]) begin tx_done = 1; idle(1); tx_done = 0; end
                    else idle(DLY);
                    m_txr = 1;
                    bus_rd(A_TXC);
                    check(rd_val == ctrl_word(m_txr, m_txie), "R7 rand tx ctrl", rd_val, ctrl_word(m_txr, m_txie));
                    bus_rd(A_TXD);
                    check(rd_val == {24'h0, m_txb}, "R10 rand tx data", rd_val, {24'h0, m_txb});
                end
            endcase
            chk_irq("R9 rand irq");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule